// File: doc/BRIEF.md
# Next-Address and Branch Unit

This block owns the instruction address of a 16-bit single-cycle processor. Every clock it works out the next fetch address from the decoded opcode and subop, the value read from the first source register and the 8-bit immediate. The instruction is either a sign or zero test on one register, an absolute jump, a jump-and-link, a jump through a register, a halt, or any other instruction, which simply advances the address.

The current address and its successor are both held in registers. The successor serves as the return address that the register file stores for jump-and-link. A halt instruction freezes the address for good and raises a halt flag. Only a synchronous reset clears it.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the unit goes to `pc_out` = 0x00, `link_out` = 0x01 and `halted` = 0 after that edge.
- R2: When not halted, any opcode other than 1010, 1011, 0101, 1100, 1101 or 0110 advances `pc_out` by one at the next edge, and 0xFF wraps to 0x00. For example, opcode 0000, 0111 and 1000 all advance.
- R3: With opcode 1010 and subop 0, `pc_out` becomes `imm` when `rs_val`, read as a signed 16-bit number, is greater than zero. Otherwise it becomes `pc_out`+1.
- R4: With opcode 1010 and subop 1, `pc_out` becomes `imm` when `rs_val` is negative (bit 15 set). Otherwise it becomes `pc_out`+1.
- R5: With opcode 1011, subop 0 jumps to `imm` when `rs_val` is nonzero, and subop 1 jumps to `imm` when `rs_val` is zero. When the test fails, `pc_out` becomes `pc_out`+1.
- R6: Opcode 1101 loads `imm` into `pc_out` whatever the value of subop.
- R7: `link_out` always equals `pc_out`+1 modulo 256. Opcode 1100 loads `imm` into `pc_out` whatever the value of subop.
- R8: Opcode 0101 loads `rs_val[7:0]` into `pc_out` whatever the value of subop.
- R9: Opcode 0110 sets `halted` at the next edge and keeps `pc_out` where it was. From then on every input except `rst` is ignored: `pc_out` and `halted` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Decoded opcode |
| subop | input | 1 | Decoded subop bit |
| rs_val | input | 16 | Value of the first source register |
| imm | input | 8 | Immediate field, used as an absolute target |
| pc_out | output | 8 | Current fetch address |
| link_out | output | 8 | Current address plus one, the return address for jump-and-link |
| halted | output | 1 | Halt indicator |

## Verification
The bench targets the sign-test edges of the branch conditions:
- 0x8000 and 0x0000 must not take the greater-than branch, and 0x7FFF must take it. A design that compared without sign would jump on 0x8000.
- A zero value must not take the less-than branch. A design that treated zero as negative would jump on it.
- Subop must not change j, jal or jr. A decoder that used subop for these would send jumps with subop 1 to the wrong address.

It also runs the address from 0xFF on to 0x00, which catches a carry-out leak or a saturating counter. It then issues a jump after a halt, which exposes any unit that keeps fetching once halted.

// File: rtl/nxa_pkg.sv
package nxa_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_BR_SIGN = 4'b1010;
  localparam logic [OP_W-1:0] OP_BR_ZERO = 4'b1011;
  localparam logic [OP_W-1:0] OP_JREG    = 4'b0101;
  localparam logic [OP_W-1:0] OP_JLINK   = 4'b1100;
  localparam logic [OP_W-1:0] OP_JABS    = 4'b1101;
  localparam logic [OP_W-1:0] OP_STOP    = 4'b0110;

  typedef enum logic [1:0] {
    NXT_INC  = 2'd0,
    NXT_IMM  = 2'd1,
    NXT_REG  = 2'd2,
    NXT_HOLD = 2'd3
  } nxt_src_e;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import nxa_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic              subop,
  input  logic [DATA_W-1:0] rs_val,
  output logic              take
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (rs_val == '0);
    is_neg  = rs_val[DATA_W-1];
    take    = 1'b0;
    if (op == OP_BR_SIGN)
      take = subop ? is_neg : (!is_neg && !is_zero);
    else if (op == OP_BR_ZERO)
      take = subop ? is_zero : !is_zero;
  end
endmodule

// File: rtl/next_sel.sv
module next_sel
  import nxa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic              take,
  input  logic              halted,
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] rs_low,
  output logic [ADDR_W-1:0] next_pc,
  output logic              halt_set
);
  logic [ADDR_W-1:0] imm_ext;
  nxt_src_e          src;

  generate
    if (IMM_W < ADDR_W) begin : g_zext
      assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    halt_set = 1'b0;
    if (halted) begin
      src = NXT_HOLD;
    end else begin
      unique case (op)
        OP_BR_SIGN, OP_BR_ZERO: src = take ? NXT_IMM : NXT_INC;
        OP_JLINK, OP_JABS:      src = NXT_IMM;
        OP_JREG:                src = NXT_REG;
        OP_STOP: begin
          src      = NXT_HOLD;
          halt_set = 1'b1;
        end
        default:                src = NXT_INC;
      endcase
    end

    unique case (src)
      NXT_IMM:  next_pc = imm_ext;
      NXT_REG:  next_pc = rs_low;
      NXT_HOLD: next_pc = pc;
      default:  next_pc = pc + ADDR_W'(1);
    endcase
  end
endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              halt_set,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] link,
  output logic              halted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      link   <= ADDR_W'(1);
      halted <= 1'b0;
    end else begin
      pc     <= next_pc;
      link   <= next_pc + ADDR_W'(1);
      halted <= halted | halt_set;
    end
  end

  // R7: the successor register tracks the address register
  assert_link_track_R7: assert property (@(posedge clk) disable iff (rst)
    link == pc + ADDR_W'(1));

  // R9: halted is sticky and the address is frozen while halted
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc)));

  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && !halted));
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import nxa_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op,
  input  logic              subop,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] link_out,
  output logic              halted
);
  logic              take;
  logic [ADDR_W-1:0] next_pc;
  logic              halt_set;

  cond_eval #(.DATA_W(DATA_W)) u_cond (
    .op     (op),
    .subop  (subop),
    .rs_val (rs_val),
    .take   (take)
  );

  next_sel #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_sel (
    .op       (op),
    .take     (take),
    .halted   (halted),
    .pc       (pc_out),
    .imm      (imm),
    .rs_low   (rs_val[ADDR_W-1:0]),
    .next_pc  (next_pc),
    .halt_set (halt_set)
  );

  pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .next_pc  (next_pc),
    .halt_set (halt_set),
    .pc       (pc_out),
    .link     (link_out),
    .halted   (halted)
  );

  // R6: absolute jump lands on the immediate
  assert_jabs_target_R6: assert property (@(posedge clk) disable iff (rst)
    (!halted && op == OP_JABS) |=> pc_out == ADDR_W'($past(imm)));

  // R2: an instruction that does not change control flow advances the address
  assert_plain_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (!halted && op == 4'b0000) |=> pc_out == $past(pc_out) + ADDR_W'(1));

  // R9: halt raises the flag at the next edge
  assert_halt_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (!halted && op == OP_STOP) |=> (halted && $stable(pc_out)));
endmodule

// File: tb/pc_seq_unit_tb.sv
module pc_seq_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = 4'b0000;
  logic        subop = 1'b0;
  logic [15:0] rs_val = 16'h0;
  logic [7:0]  imm = 8'h0;
  logic [7:0]  pc_out;
  logic [7:0]  link_out;
  logic        halted;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pc_seq_unit u_dut (
    .clk(clk), .rst(rst), .op(op), .subop(subop), .rs_val(rs_val),
    .imm(imm), .pc_out(pc_out), .link_out(link_out), .halted(halted)
  );

  // {req, op, subop, rs_val, imm, expected pc} applied from pc 0x40
  localparam int NV = 18;
  localparam logic [40:0] VEC [0:NV-1] = '{
    {4'd3, 4'b1010, 1'b0, 16'h0001, 8'h10, 8'h10},  // R3 positive
    {4'd3, 4'b1010, 1'b0, 16'h0000, 8'h10, 8'h41},  // R3 zero
    {4'd3, 4'b1010, 1'b0, 16'h8000, 8'h10, 8'h41},  // R3 most negative
    {4'd3, 4'b1010, 1'b0, 16'h7FFF, 8'h11, 8'h11},  // R3 most positive
    {4'd4, 4'b1010, 1'b1, 16'h8000, 8'h12, 8'h12},  // R4 negative
    {4'd4, 4'b1010, 1'b1, 16'h0000, 8'h12, 8'h41},  // R4 zero
    {4'd4, 4'b1010, 1'b1, 16'h0005, 8'h12, 8'h41},  // R4 positive
    {4'd5, 4'b1011, 1'b0, 16'h0100, 8'h13, 8'h13},  // R5 nonzero
    {4'd5, 4'b1011, 1'b0, 16'h0000, 8'h13, 8'h41},  // R5 zero
    {4'd5, 4'b1011, 1'b1, 16'h0000, 8'h14, 8'h14},  // R5 zero test
    {4'd5, 4'b1011, 1'b1, 16'h0001, 8'h14, 8'h41},  // R5 zero test fails
    {4'd6, 4'b1101, 1'b0, 16'h0000, 8'h9A, 8'h9A},  // R6
    {4'd6, 4'b1101, 1'b1, 16'h0000, 8'h07, 8'h07},  // R6 subop ignored
    {4'd7, 4'b1100, 1'b1, 16'h0000, 8'h33, 8'h33},  // R7 jal
    {4'd8, 4'b0101, 1'b0, 16'hABCD, 8'h00, 8'hCD},  // R8
    {4'd8, 4'b0101, 1'b1, 16'h0012, 8'h55, 8'h12},  // R8 subop ignored
    {4'd2, 4'b0000, 1'b0, 16'h0000, 8'h99, 8'h41},  // R2
    {4'd2, 4'b1000, 1'b1, 16'h0000, 8'h77, 8'h41}   // R2
  };

  task automatic step(input logic [3:0] o, input logic s,
                      input logic [15:0] r, input logic [7:0] i);
    op = o; subop = s; rs_val = r; imm = i;
    @(negedge clk);
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    step(4'b0000, 1'b0, 16'h0, 8'h0);
    rst = 1'b0;
    // R1 reset state
    chk8("R1 pc", pc_out, 8'h00);
    chk8("R1 link", link_out, 8'h01);
    chk8("R1 halted", {7'b0, halted}, 8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [40:0] v;
      v = VEC[k];
      step(4'b1101, 1'b0, 16'h0, 8'h40);
      chk8("R7 link before", link_out, 8'h41);
      step(v[36:33], v[32], v[31:16], v[15:8]);
      n_run++;
      if (pc_out !== v[7:0]) begin
        n_fail++;
        $display("FAIL R%0d vec %0d actual=%h expected=%h", v[40:37], k, pc_out, v[7:0]);
      end
    end

    // R2 wrap
    step(4'b1101, 1'b0, 16'h0, 8'hFE);
    step(4'b0000, 1'b0, 16'h0, 8'h0);
    chk8("R2 at FF", pc_out, 8'hFF);
    chk8("R7 link wrap", link_out, 8'h00);
    step(4'b0111, 1'b0, 16'h0, 8'h0);
    chk8("R2 wrap", pc_out, 8'h00);

    // R9 halt
    step(4'b1101, 1'b0, 16'h0, 8'h20);
    step(4'b0110, 1'b1, 16'h0, 8'h0);
    chk8("R9 pc hold", pc_out, 8'h20);
    chk8("R9 halted", {7'b0, halted}, 8'h01);
    step(4'b1101, 1'b0, 16'h0, 8'h55);
    chk8("R9 jump ignored", pc_out, 8'h20);
    step(4'b0101, 1'b0, 16'h0077, 8'h0);
    chk8("R9 jr ignored", pc_out, 8'h20);
    chk8("R9 still halted", {7'b0, halted}, 8'h01);
    rst = 1'b1;
    step(4'b0000, 1'b0, 16'h0, 8'h0);
    rst = 1'b0;
    chk8("R1 halt cleared", {7'b0, halted}, 8'h00);
    chk8("R1 pc after halt", pc_out, 8'h00);
    step(4'b0000, 1'b0, 16'h0, 8'h0);
    chk8("R2 runs after reset", pc_out, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule